// File: doc/BRIEF.md
# Dual-Mode SPI Shift Controller

This block is one SPI shift engine that serves as either bus master or bus slave, chosen by a mode input. It moves 8-bit frames between a system-side byte interface and the serial pins. The system side has a one-byte transmit holding register and a one-byte receive register, each with a valid/ready handshake, plus a busy flag. The pin side has separate serial data in and out, output enables for serial data out and for the serial clock, a serial clock input and output, an active-low select input, and pull requests for each input pad.

As master, the block makes the serial clock from the system clock with a programmable even divider. The idle level (CPOL) and the sampling edge (CPHA) can be set. Any select line toward an external device is produced outside the block. As slave, the external clock, select and data inputs each pass through a two-flop synchronizer and are edge-detected in the system clock domain. The external clock must run at no more than a quarter of the system clock rate. Releasing select in the middle of a frame throws away the partial frame.

Configuration inputs are expected to stay stable while `busy_o` is high.

Top module: `spi_dual_ctrl`

## Requirements
- R1: In master mode (`cfg_slave_i`=0), `sdo_oe_o` and `sclk_oe_o` are 1 on every cycle, and `ss_ni` has no effect on a transfer.
- R2: In master mode, `sclk_o` rests at the `cfg_cpol_i` level when idle. A frame makes exactly 16 clock edges and holds `busy_o` high for 16*(`cfg_div_i`+1) system cycles.
- R3: A leading edge is the one that leaves the CPOL level. With `cfg_cpha_i`=0 a bit is sampled on the leading edge and the output changes on the trailing edge. With `cfg_cpha_i`=1 the output changes on the leading edge and a bit is sampled on the trailing edge.
- R4: With `cfg_lsb_first_i`=1 bit 0 is shifted first and with 0 bit 7 is shifted first. The same order applies to both transmit and receive.
- R5: `tx_ready_o` is 1 exactly when the holding register is empty, and a byte is taken on a cycle with `tx_valid_i` and `tx_ready_o` both high. A master frame starts only when the holding register is full.
- R6: After the 8th sample, `rx_data_o` holds the received byte and `rx_valid_o` stays 1 until a cycle with `rx_ready_i`=1.
- R7: In slave mode, `sdo_oe_o` equals the inverse of `ss_ni`, `sclk_oe_o` is 0, and `busy_o` is 1 while the synchronized select is low.
- R8: In slave mode, while `ss_ni` is high, edges on `sclk_i` and data on `sdi_i` shift nothing and produce no `rx_valid_o`.
- R9: In slave mode, a rise of `ss_ni` mid-frame clears the bit count and discards the partial byte with no `rx_valid_o`. The next frame is received from its first bit.
- R10: In slave mode, the first bit of the next byte is on `sdo_o` before select falls, so with CPHA 0 it is valid at once. If no new byte is held at frame start, the previous byte is sent again.
- R11: Pull outputs use `pull_en_*`=1 to request a pull and `pull_up_*`=1 for up, 0 for down. With `cfg_pull_en_i`=0 all six outputs are 0. With it set, SDI always requests a pull-up. In slave mode SS requests a pull-up and SCLK requests a pull equal to CPOL (up for 1, down for 0). In master mode SCLK and SS request nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_slave_i | input | 1 | 1 = slave mode, 0 = master mode |
| cfg_cpol_i | input | 1 | Serial clock idle level |
| cfg_cpha_i | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_lsb_first_i | input | 1 | 1 = bit 0 first |
| cfg_pull_en_i | input | 1 | Global pull request enable |
| cfg_div_i | input | DIV_W | Master half-period length minus one, in system cycles |
| tx_data_i | input | DATA_W | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Holding register empty |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Received byte taken |
| busy_o | output | 1 | Frame in progress |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data out enable |
| sclk_i | input | 1 | Serial clock from external master |
| sclk_o | output | 1 | Serial clock driven as master |
| sclk_oe_o | output | 1 | Serial clock output enable |
| ss_ni | input | 1 | Slave select, active low |
| pull_en_sdi_o | output | 1 | Pull request, SDI pad |
| pull_up_sdi_o | output | 1 | Pull direction, SDI pad |
| pull_en_sclk_o | output | 1 | Pull request, SCLK pad |
| pull_up_sclk_o | output | 1 | Pull direction, SCLK pad |
| pull_en_ss_o | output | 1 | Pull request, SS pad |
| pull_up_ss_o | output | 1 | Pull direction, SS pad |

## Verification
On every cycle, the assertions check these properties: the bit counter is zero after any cycle in which a deselected slave was seen, a receive pulse follows only a seventh-count sample, the master clock rests at CPOL when idle, a master frame starts only with a byte held, the holding register fills only on an offered byte, and pulls stay off when disabled. Other behaviours only show up in the bench's scenarios. These are the serial bit order at each CPOL/CPHA pairing, the 16-edge frame length at different dividers, the loopback of received bytes, the preloaded first slave bit, the repeat of the previous byte, and the clean restart after an aborted frame.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
  // one system-cycle strobes marking serial clock edges
  typedef struct packed {
    logic lead;
    logic trail;
  } spi_edge_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_dual_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cpol_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             run_o,
  output spi_edge_t        ev_o
);
  localparam int TOG_N = 2 * DATA_W;
  localparam int TOG_W = $clog2(TOG_N);

  logic             run_q, ph_q;
  logic [DIV_W-1:0] half_q;
  logic [TOG_W-1:0] tog_q;
  logic             tick;

  assign tick = run_q && (half_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ph_q   <= 1'b0;
      half_q <= '0;
      tog_q  <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q  <= 1'b1;
        ph_q   <= 1'b0;
        half_q <= '0;
        tog_q  <= '0;
      end
    end else if (tick) begin
      half_q <= '0;
      ph_q   <= ~ph_q;
      tog_q  <= tog_q + 1'b1;
      if (tog_q == TOG_W'(TOG_N - 1)) run_q <= 1'b0;
    end else begin
      half_q <= half_q + 1'b1;
    end
  end

  // ph_q=1 means the clock is away from its idle level
  assign sclk_o     = cpol_i ^ ph_q;
  assign run_o      = run_q;
  assign ev_o.lead  = tick && !ph_q;
  assign ev_o.trail = tick && ph_q;
endmodule

// File: rtl/spi_pull.sv
module spi_pull (
  input  logic slave_i,
  input  logic cpol_i,
  input  logic en_i,
  output logic en_sdi_o,
  output logic up_sdi_o,
  output logic en_sclk_o,
  output logic up_sclk_o,
  output logic en_ss_o,
  output logic up_ss_o
);
  assign en_sdi_o  = en_i;
  assign up_sdi_o  = en_i;
  assign en_sclk_o = en_i & slave_i;
  assign up_sclk_o = en_i & slave_i & cpol_i;
  assign en_ss_o   = en_i & slave_i;
  assign up_ss_o   = en_i & slave_i;
endmodule

// File: rtl/spi_dual_ctrl.sv
module spi_dual_ctrl
  import spi_dual_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_slave_i,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic              cfg_lsb_first_i,
  input  logic              cfg_pull_en_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              busy_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              ss_ni,
  output logic              pull_en_sdi_o,
  output logic              pull_up_sdi_o,
  output logic              pull_en_sclk_o,
  output logic              pull_up_sclk_o,
  output logic              pull_en_ss_o,
  output logic              pull_up_ss_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  // slave input synchronizers, order {ss, sclk, sdi}
  logic [2:0] sync_q;
  logic       ss_s, sclk_s, sdi_s;
  spi_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sclk_i, sdi_i}),
    .q_o   (sync_q)
  );
  assign {ss_s, sclk_s, sdi_s} = sync_q;

  logic              tx_full_q, act_q, sclk_prev_q;
  logic [DATA_W-1:0] tx_hold_q, tx_last_q, tx_sh_q, rx_sh_q, rx_nxt, next_byte;
  logic [CNT_W-1:0]  cnt_q;
  logic              m_start, m_run, m_sclk, s_start, reload, load, deselect;
  logic              samp_bit, sample, shift, done, take;
  spi_edge_t         m_ev, s_ev, ev;

  assign m_start = !cfg_slave_i && !m_run && tx_full_q;

  spi_clkgen #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(m_start),
    .cpol_i (cfg_cpol_i),
    .div_i  (cfg_div_i),
    .sclk_o (m_sclk),
    .run_o  (m_run),
    .ev_o   (m_ev)
  );

  spi_pull i_pull (
    .slave_i  (cfg_slave_i),
    .cpol_i   (cfg_cpol_i),
    .en_i     (cfg_pull_en_i),
    .en_sdi_o (pull_en_sdi_o),
    .up_sdi_o (pull_up_sdi_o),
    .en_sclk_o(pull_en_sclk_o),
    .up_sclk_o(pull_up_sclk_o),
    .en_ss_o  (pull_en_ss_o),
    .up_ss_o  (pull_up_ss_o)
  );

  // slave edge detection, gated by the live synchronized select
  logic s_rise, s_fall, s_live;
  assign s_rise     = sclk_s & ~sclk_prev_q;
  assign s_fall     = ~sclk_s & sclk_prev_q;
  assign s_live     = act_q & ~ss_s;
  assign s_ev.lead  = s_live & (cfg_cpol_i ? s_fall : s_rise);
  assign s_ev.trail = s_live & (cfg_cpol_i ? s_rise : s_fall);

  assign ev       = cfg_slave_i ? s_ev : m_ev;
  assign samp_bit = cfg_slave_i ? sdi_s : sdi_i;
  assign deselect = cfg_slave_i && ss_s;
  assign s_start  = cfg_slave_i && !ss_s && !act_q;

  assign sample = cfg_cpha_i ? ev.trail : ev.lead;
  assign shift  = cfg_cpha_i ? (ev.lead && cnt_q != '0)
                             : (ev.trail && cnt_q != CNT_W'(DATA_W));
  assign done   = sample && (cnt_q == CNT_W'(DATA_W - 1));
  // back-to-back slave frames reload after the last bit
  assign reload = s_live && (cfg_cpha_i ? done : (ev.trail && cnt_q == CNT_W'(DATA_W)));
  assign load   = m_start || s_start || reload;

  assign next_byte = tx_full_q ? tx_hold_q : tx_last_q;
  assign rx_nxt    = cfg_lsb_first_i ? {samp_bit, rx_sh_q[DATA_W-1:1]}
                                     : {rx_sh_q[DATA_W-2:0], samp_bit};
  assign take      = tx_valid_i && !tx_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_full_q   <= 1'b0;
      tx_hold_q   <= '0;
      tx_last_q   <= '0;
      tx_sh_q     <= '0;
      rx_sh_q     <= '0;
      rx_data_o   <= '0;
      rx_valid_o  <= 1'b0;
      cnt_q       <= '0;
      act_q       <= 1'b0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      act_q       <= cfg_slave_i && !ss_s;

      if (take) begin
        tx_hold_q <= tx_data_i;
        tx_full_q <= 1'b1;
      end else if (load && tx_full_q) begin
        tx_full_q <= 1'b0;
      end

      if (done) begin
        rx_data_o  <= rx_nxt;
        rx_valid_o <= 1'b1;
      end else if (rx_ready_i) begin
        rx_valid_o <= 1'b0;
      end

      if (sample) rx_sh_q <= rx_nxt;

      if (load) begin
        tx_sh_q   <= next_byte;
        tx_last_q <= next_byte;
        cnt_q     <= '0;
      end else if (deselect) begin
        cnt_q <= '0;
      end else begin
        if (sample) cnt_q <= cnt_q + 1'b1;
        if (shift) begin
          tx_sh_q <= cfg_lsb_first_i ? {1'b0, tx_sh_q[DATA_W-1:1]}
                                     : {tx_sh_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  logic cur_bit, pre_bit;
  assign cur_bit = cfg_lsb_first_i ? tx_sh_q[0] : tx_sh_q[DATA_W-1];
  assign pre_bit = cfg_lsb_first_i ? next_byte[0] : next_byte[DATA_W-1];

  // idle slave shows the first bit of the byte it will commit
  assign sdo_o      = (cfg_slave_i && !act_q) ? pre_bit : cur_bit;
  assign sdo_oe_o   = cfg_slave_i ? ~ss_ni : 1'b1;
  assign sclk_o     = m_sclk;
  assign sclk_oe_o  = ~cfg_slave_i;
  assign busy_o     = cfg_slave_i ? act_q : m_run;
  assign tx_ready_o = ~tx_full_q;

  // R9
  deselect_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_slave_i && ss_s) |=> (cnt_q == '0));
  // R6
  rx_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> ($past(cnt_q) == CNT_W'(DATA_W - 1)));
  // R2
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_slave_i && !m_run) |-> (sclk_o == cfg_cpol_i));
  // R5
  start_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_run) |-> $past(tx_full_q));
  // R5
  tx_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ready_o) |-> $past(tx_valid_i));
  // R11
  pull_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_pull_en_i |-> !(pull_en_sdi_o || pull_en_sclk_o || pull_en_ss_o ||
                         pull_up_sdi_o || pull_up_sclk_o || pull_up_ss_o));
endmodule

// File: tb/test_spi_dual_ctrl.sv
module test_spi_dual_ctrl;
  localparam int H = 6;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_slave = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0, cfg_pe = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0, rx_ready = 1'b1;
  logic       sdi_drv = 1'b0, lb = 1'b0, sclk_in = 1'b0, ss_n = 1'b1;
  logic       sdi;
  logic       tx_ready, rx_valid, busy, sdo, sdo_oe, sclk_out, sclk_oe;
  logic [7:0] rx_data;
  logic       pe_sdi, pu_sdi, pe_sclk, pu_sclk, pe_ss, pu_ss;

  always #2 clk = ~clk;
  assign sdi = lb ? sdo : sdi_drv;

  spi_dual_ctrl i_spi_dual_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_slave_i(cfg_slave), .cfg_cpol_i(cfg_cpol), .cfg_cpha_i(cfg_cpha),
    .cfg_lsb_first_i(cfg_lsb), .cfg_pull_en_i(cfg_pe), .cfg_div_i(cfg_div),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .busy_o(busy), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .sclk_i(sclk_in), .sclk_o(sclk_out), .sclk_oe_o(sclk_oe), .ss_ni(ss_n),
    .pull_en_sdi_o(pe_sdi), .pull_up_sdi_o(pu_sdi),
    .pull_en_sclk_o(pe_sclk), .pull_up_sclk_o(pu_sclk),
    .pull_en_ss_o(pe_ss), .pull_up_ss_o(pu_ss)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // receive monitor: scoreboard pop
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rxq.size() == 0) chk(0, "R8/R9 unexpected rx_valid", rx_data, 0);
      else begin
        logic [7:0] e;
        e = rxq.pop_front();
        chk(rx_data == e, "R6 received byte", rx_data, e);
      end
    end
  end

  // master serial monitor: samples sdo on the sampling edge
  logic       prev_sclk = 1'b0;
  logic [7:0] msh = '0;
  int         mnb = 0, tog_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && !cfg_slave && sclk_out !== prev_sclk) begin
      bit lead;
      tog_cnt++;
      lead = (sclk_out != cfg_cpol);
      if (cfg_cpha ? !lead : lead) begin
        msh = cfg_lsb ? {sdo, msh[7:1]} : {msh[6:0], sdo};
        mnb++;
        if (mnb == 8) begin
          mnb = 0;
          if (txq.size() == 0) chk(0, "R3 unexpected master frame", msh, 0);
          else begin
            logic [7:0] e;
            e = txq.pop_front();
            chk(msh == e, "R3/R4 master serial order", msh, e);
          end
        end
      end
    end
    prev_sclk = sclk_out;
  end

  task automatic write_tx(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic master_xfer(input logic [7:0] b, input bit cpol, input bit cpha,
                             input bit lsb, input logic [7:0] div, input bit tog_ss);
    int  nbusy = 0;
    bit  oe_ok = 1;
    cfg_slave = 0; cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb = lsb; cfg_div = div; lb = 1;
    repeat (3) @(negedge clk);
    #1;
    mnb = 0; tog_cnt = 0;
    txq.push_back(b);
    rxq.push_back(b);
    chk(busy == 0, "R5 no start without data", busy, 0);
    write_tx(b);
    while (!busy) @(negedge clk);
    while (busy) begin
      nbusy++;
      if (tog_ss) ss_n = ~ss_n;
      if (!(sdo_oe && sclk_oe)) oe_ok = 0;
      @(negedge clk);
    end
    ss_n = 1;
    chk(oe_ok, "R1 master output enables", oe_ok, 1);
    chk(nbusy == 16 * (int'(div) + 1), "R2 frame length", nbusy, 16 * (int'(div) + 1));
    repeat (3) @(negedge clk);
    chk(tog_cnt == 16, "R2 edge count", tog_cnt, 16);
    chk(sclk_out == cpol, "R2 idle level", sclk_out, cpol);
  endtask

  task automatic slave_frame(input logic [7:0] mosi, input int nbits, input bit full);
    logic [7:0] ssh = '0;
    cfg_slave = 1; lb = 0;
    sclk_in = cfg_cpol;
    if (full) rxq.push_back(mosi);
    if (!cfg_cpha) sdi_drv = cfg_lsb ? mosi[0] : mosi[7];
    @(negedge clk);
    ss_n = 0;
    repeat (H) @(negedge clk);
    chk(busy == 1 && sdo_oe == 1 && sclk_oe == 0, "R7 slave selected",
        {busy, sdo_oe, sclk_oe}, 3'b110);
    for (int i = 0; i < nbits; i++) begin
      if (!cfg_cpha) begin
        ssh = cfg_lsb ? {sdo, ssh[7:1]} : {ssh[6:0], sdo};
        sclk_in = ~cfg_cpol;
        repeat (H) @(negedge clk);
        sclk_in = cfg_cpol;
        if (i < 7) sdi_drv = cfg_lsb ? mosi[i+1] : mosi[6-i];
        repeat (H) @(negedge clk);
      end else begin
        sclk_in = ~cfg_cpol;
        sdi_drv = cfg_lsb ? mosi[i] : mosi[7-i];
        repeat (H) @(negedge clk);
        ssh = cfg_lsb ? {sdo, ssh[7:1]} : {ssh[6:0], sdo};
        sclk_in = cfg_cpol;
        repeat (H) @(negedge clk);
      end
    end
    if (full) begin
      logic [7:0] e;
      e = txq.pop_front();
      chk(ssh == e, "R4/R10 slave serial out", ssh, e);
    end
    ss_n = 1;
    repeat (H) @(negedge clk);
    chk(sdo_oe == 0 && busy == 0, "R7 slave deselected", {sdo_oe, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_ready == 1 && rx_valid == 0 && busy == 0 && sclk_out == 0, "R5 reset state",
        {tx_ready, rx_valid, busy, sclk_out}, 4'b1000);

    // R11 pull encodings
    chk({pe_sdi, pu_sdi, pe_sclk, pu_sclk, pe_ss, pu_ss} == 6'b0, "R11 pulls off",
        {pe_sdi, pu_sdi, pe_sclk, pu_sclk, pe_ss, pu_ss}, 0);
    cfg_pe = 1; #1;
    chk({pe_sdi, pu_sdi, pe_sclk, pu_sclk, pe_ss, pu_ss} == 6'b110000, "R11 master pulls",
        {pe_sdi, pu_sdi, pe_sclk, pu_sclk, pe_ss, pu_ss}, 6'b110000);
    cfg_slave = 1; #1;
    chk({pe_sdi, pu_sdi, pe_sclk, pu_sclk, pe_ss, pu_ss} == 6'b111011, "R11 slave cpol0 pulls",
        {pe_sdi, pu_sdi, pe_sclk, pu_sclk, pe_ss, pu_ss}, 6'b111011);
    cfg_cpol = 1; #1;
    chk({pe_sdi, pu_sdi, pe_sclk, pu_sclk, pe_ss, pu_ss} == 6'b111111, "R11 slave cpol1 pulls",
        {pe_sdi, pu_sdi, pe_sclk, pu_sclk, pe_ss, pu_ss}, 6'b111111);
    chk(sdo_oe == 0 && sclk_oe == 0, "R7 slave idle enables", {sdo_oe, sclk_oe}, 0);
    cfg_pe = 0; cfg_slave = 0; cfg_cpol = 0;

    // master frames over CPOL/CPHA/order/divider
    master_xfer(8'hA5, 0, 0, 0, 8'd1, 0);
    master_xfer(8'h3C, 1, 0, 1, 8'd2, 1);
    master_xfer(8'h96, 0, 1, 1, 8'd0, 1);
    master_xfer(8'hE1, 1, 1, 0, 8'd3, 0);

    // slave, CPHA 0: first bit preloaded before select falls
    cfg_slave = 1; cfg_cpol = 0; cfg_cpha = 0; cfg_lsb = 0; sclk_in = 0;
    write_tx(8'hD2);
    repeat (4) @(negedge clk);
    chk(sdo == 1'b1, "R10 preloaded first bit", sdo, 1);
    txq.push_back(8'hD2);
    slave_frame(8'hC3, 8, 1);

    cfg_cpol = 1; cfg_cpha = 1; cfg_lsb = 1;
    write_tx(8'h81);
    txq.push_back(8'h81);
    slave_frame(8'h7E, 8, 1);

    // R8: clock and data activity while deselected
    for (int i = 0; i < 16; i++) begin
      sclk_in = ~sclk_in;
      sdi_drv = i[0];
      repeat (H) @(negedge clk);
    end
    sclk_in = cfg_cpol;
    repeat (H) @(negedge clk);
    chk(busy == 0, "R8 deselected stays idle", busy, 0);

    // R9: abort after 3 bits, then a clean frame repeating the byte (R10)
    cfg_cpol = 0; cfg_cpha = 1; cfg_lsb = 0; sclk_in = 0;
    repeat (H) @(negedge clk);
    write_tx(8'hB4);
    slave_frame(8'hF0, 3, 0);
    txq.push_back(8'hB4);
    slave_frame(8'h69, 8, 1);
    cfg_cpol = 1; cfg_cpha = 0; cfg_lsb = 1; sclk_in = 1;
    repeat (H) @(negedge clk);
    txq.push_back(8'hB4);
    slave_frame(8'h0F, 8, 1);

    repeat (10) @(negedge clk);
    chk(rxq.size() == 0 && txq.size() == 0, "R6 scoreboard drained",
        rxq.size() + txq.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule